// File: doc/BRIEF.md
# Runahead Execution Mode Controller

This block decides when an out-of-order core leaves normal retirement for speculative pre-execution, and when it comes back. It watches the head of the instruction window. When the oldest instruction is a load that missed in the data cache, the block first asks the core to take a checkpoint. The checkpoint covers the committed register values, the rename map, the return-address stack and the global branch history. The block then switches to runahead mode.

In runahead mode the retiring instructions change no architectural state. The load that missed gets a bogus result, so its destination register is marked poisoned. Poison spreads to every result computed from a poisoned source. Loads with a usable address and no earlier speculative store to the same address go out as prefetches. Loads whose address is poisoned issue nothing.

Speculative stores go into a small associative side buffer rather than the cache, so later speculative loads can read them. When the miss data returns, the block spends one cycle restoring the checkpoint and flushing the pipeline. In that cycle it clears all poison state and the side buffer, and gives the fetch unit the address of the missing load to restart from. The datapath, the caches and the checkpoint storage itself live outside this block.

Top module: `runahead_ctrl`

## Requirements
- R1: During and right after synchronous reset the controller is in normal mode: all outputs are 0, with no poison bit set and the side buffer empty.
- R2: `head_miss_i` high in normal mode makes `ckpt_save_o` high in the next cycle, for exactly one cycle. `head_pc_i` and `head_dst_i` are captured on that same edge.
- R3: After the save cycle, if no miss return arrived during it, `commit_suppress_o` is high from the next cycle on. It stays high until the return is seen. It is high in no other cycle.
- R4: `miss_return_i` high in runahead mode gives, in the next cycle, exactly one cycle with `ckpt_restore_o` and `flush_o` high and `restart_pc_o` equal to the captured PC. `restart_pc_o` is 0 at all other times. Normal mode follows.
- R5: `miss_return_i` high in the save cycle goes straight to the restore cycle, with no cycle of `commit_suppress_o`.
- R6: The captured destination register becomes poisoned as the save cycle ends. Register 0 is never poisoned.
- R7: In runahead mode, a retiring instruction with `ret_is_load_i`=0 and `ret_is_store_i`=0 has `ret_poison_o` equal to the OR of the poison bits of `ret_src1_i` and `ret_src2_i`. If `ret_dst_we_i`=1, this value overwrites the poison bit of `ret_dst_i`, so a clean result clears it.
- R8: A runahead load uses `ret_src1_i` as its address register. If that register is poisoned, the load raises no prefetch and its result is poisoned. If the address is clean and misses the side buffer, `pf_valid_o`=1 with `pf_addr_o`=`ret_addr_i`, and the result is clean.
- R9: A runahead store (`ret_is_store_i`=1 takes priority over `ret_is_load_i`) with a clean address register writes `ret_data_i` and the poison bit of `ret_src2_i` into the side buffer. A store with a poisoned address writes nothing. A later load that hits gives `fwd_hit_o`=1, `fwd_data_o` equal to the stored data, no prefetch, and `ret_poison_o` equal to the stored poison bit. `fwd_data_o` is 0 on a miss.
- R10: A store to an address already in the side buffer updates that entry in place. A store to a new address while the buffer is full replaces the oldest entry.
- R11: The restore cycle clears every poison bit and empties the side buffer.
- R12: Outside runahead mode the retirement inputs have no effect: no prefetch, no forwarding, no poison output, and no change to poison or buffer state. `head_miss_i` is ignored outside normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_miss_i | input | 1 | Oldest window instruction is a data cache miss |
| head_pc_i | input | 32 | PC of the oldest instruction |
| head_dst_i | input | 5 | Destination register of the oldest instruction |
| miss_return_i | input | 1 | Data for the blocking miss has returned |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_is_load_i | input | 1 | Retiring instruction is a load |
| ret_is_store_i | input | 1 | Retiring instruction is a store |
| ret_dst_we_i | input | 1 | Retiring instruction writes a register |
| ret_dst_i | input | 5 | Destination register |
| ret_src1_i | input | 5 | First source / address register |
| ret_src2_i | input | 5 | Second source / store data register |
| ret_addr_i | input | 32 | Effective address of a load or store |
| ret_data_i | input | 32 | Store data |
| ckpt_save_o | output | 1 | Save checkpoint this cycle |
| ckpt_restore_o | output | 1 | Restore checkpoint this cycle |
| flush_o | output | 1 | Flush pipeline this cycle |
| commit_suppress_o | output | 1 | Retirement frees entries but writes no state |
| restart_pc_o | output | 32 | Fetch restart address, valid in the restore cycle |
| ret_poison_o | output | 1 | Result of the retiring instruction is poisoned |
| pf_valid_o | output | 1 | Issue a prefetch |
| pf_addr_o | output | 32 | Prefetch address |
| fwd_hit_o | output | 1 | Load hit in the side buffer |
| fwd_data_o | output | 32 | Data forwarded from the side buffer |

## Verification
The hardest case to reach is a miss return that lands in the single save cycle: the return must arrive exactly one cycle after the head miss. Directed stimulus does this, and the random phase raises both inputs often enough to hit it again. Replacing the oldest buffer entry while another entry is updated in place is also hard to provoke. The bench drives a fixed run of five distinct store addresses with a repeated address in the middle, then loads each address. A behavioural reference model follows every cycle of a long random run with a small pool of registers and addresses, so poison chains and evictions keep recurring.

// File: rtl/ra_pkg.sv
package ra_pkg;
    parameter int RA_ADDR_W = 32;
    parameter int RA_DATA_W = 32;
    parameter int RA_PC_W   = 32;
    parameter int RA_REG_W  = 5;

    typedef enum logic [1:0] {
        RA_NORMAL = 2'd0,
        RA_ENTER  = 2'd1,
        RA_RUN    = 2'd2,
        RA_EXIT   = 2'd3
    } ra_state_e;

    typedef enum logic [1:0] {
        K_ALU   = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2
    } ra_kind_e;

    typedef struct packed {
        logic                  valid;
        ra_kind_e              kind;
        logic                  dst_we;
        logic [RA_REG_W-1:0]   dst;
        logic [RA_REG_W-1:0]   src1;
        logic [RA_REG_W-1:0]   src2;
        logic [RA_ADDR_W-1:0]  addr;
        logic [RA_DATA_W-1:0]  data;
    } ra_retire_t;

    typedef struct packed {
        logic save;
        logic restore;
        logic flush;
        logic suppress;
    } ra_ctl_t;

    function automatic ra_kind_e ra_decode(input logic is_load, input logic is_store);
        if (is_store)     return K_STORE;
        else if (is_load) return K_LOAD;
        else              return K_ALU;
    endfunction
endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
    import ra_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 head_miss,
    input  logic [RA_PC_W-1:0]   head_pc,
    input  logic [RA_REG_W-1:0]  head_dst,
    input  logic                 miss_return,
    output ra_state_e            state,
    output ra_ctl_t              ctl,
    output logic [RA_PC_W-1:0]   restart_pc,
    output logic [RA_REG_W-1:0]  bogus_dst,
    output logic                 set_bogus,
    output logic                 clear_all
);
    ra_state_e            nxt;
    logic [RA_PC_W-1:0]   pc_q;
    logic [RA_REG_W-1:0]  dst_q;

    always_comb begin
        nxt = state;
        unique case (state)
            RA_NORMAL: if (head_miss) nxt = RA_ENTER;
            RA_ENTER:  nxt = miss_return ? RA_EXIT : RA_RUN;
            RA_RUN:    if (miss_return) nxt = RA_EXIT;
            RA_EXIT:   nxt = RA_NORMAL;
            default:   nxt = RA_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RA_NORMAL;
            pc_q  <= '0;
            dst_q <= '0;
        end else begin
            state <= nxt;
            if (state == RA_NORMAL && head_miss) begin
                pc_q  <= head_pc;
                dst_q <= head_dst;
            end
        end
    end

    always_comb begin
        ctl.save     = (state == RA_ENTER);
        ctl.restore  = (state == RA_EXIT);
        ctl.flush    = (state == RA_EXIT);
        ctl.suppress = (state == RA_RUN);
    end

    assign restart_pc = (state == RA_EXIT) ? pc_q : '0;
    assign bogus_dst  = dst_q;
    assign set_bogus  = (state == RA_ENTER);
    assign clear_all  = (state == RA_EXIT);

    p_save_after_miss_r2: assert property (@(posedge clk) disable iff (rst)
        (state == RA_NORMAL && head_miss) |=> ctl.save);
    p_save_single_r2: assert property (@(posedge clk) disable iff (rst)
        ctl.save |=> !ctl.save);
    p_run_after_save_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.save && !miss_return) |=> ctl.suppress);
    p_restore_then_normal_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.restore |=> (state == RA_NORMAL && !ctl.restore));
    p_early_return_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.save && miss_return) |=> ctl.restore);
    p_ctl_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.save, ctl.restore, ctl.suppress}));
endmodule

// File: rtl/ra_poison_tracker.sv
module ra_poison_tracker
    import ra_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_all,
    input  logic                 set_bogus,
    input  logic [RA_REG_W-1:0]  bogus_dst,
    input  logic [RA_REG_W-1:0]  rd1,
    input  logic [RA_REG_W-1:0]  rd2,
    output logic                 inv1,
    output logic                 inv2,
    input  logic                 wr_en,
    input  logic [RA_REG_W-1:0]  wr_dst,
    input  logic                 wr_val
);
    localparam int NREGS = 1 << RA_REG_W;

    logic [NREGS-1:0] inv_q;

    assign inv1 = inv_q[rd1];
    assign inv2 = inv_q[rd2];

    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            inv_q <= '0;
        end else if (set_bogus) begin
            if (bogus_dst != '0) inv_q[bogus_dst] <= 1'b1;
        end else if (wr_en && wr_dst != '0) begin
            inv_q[wr_dst] <= wr_val;
        end
    end

    p_clear_all_r11: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> (inv_q == '0));
    p_bogus_marked_r6: assert property (@(posedge clk) disable iff (rst)
        (set_bogus && !clear_all && bogus_dst != '0) |=> inv_q[$past(bogus_dst)]);
    p_reg0_clean_r6: assert property (@(posedge clk) disable iff (rst)
        !inv_q[0]);
endmodule

// File: rtl/ra_spec_store_buf.sv
module ra_spec_store_buf
    import ra_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic [RA_ADDR_W-1:0]  lk_addr,
    input  logic                  wr_en,
    input  logic [RA_DATA_W-1:0]  wr_data,
    input  logic                  wr_dinv,
    output logic                  hit,
    output logic [RA_DATA_W-1:0]  rd_data,
    output logic                  rd_dinv
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]      vld;
    logic [RA_ADDR_W-1:0]  tag [DEPTH];
    logic [RA_DATA_W-1:0]  dat [DEPTH];
    logic [DEPTH-1:0]      dinv;
    logic [DEPTH-1:0]      match;
    logic [PTR_W-1:0]      ptr;
    logic [PTR_W-1:0]      hit_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld[g] && (tag[g] == lk_addr);
    end

    always_comb begin
        hit     = |match;
        rd_data = '0;
        rd_dinv = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                rd_data = rd_data | dat[i];
                rd_dinv = rd_dinv | dinv[i];
                hit_idx = PTR_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            vld  <= '0;
            dinv <= '0;
            ptr  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag[i] <= '0;
                dat[i] <= '0;
            end
        end else if (wr_en) begin
            if (hit) begin
                dat[hit_idx]  <= wr_data;
                dinv[hit_idx] <= wr_dinv;
            end else begin
                vld[ptr]  <= 1'b1;
                tag[ptr]  <= lk_addr;
                dat[ptr]  <= wr_data;
                dinv[ptr] <= wr_dinv;
                ptr       <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
            end
        end
    end

    p_flush_empty_r11: assert property (@(posedge clk) disable iff (rst)
        clear |=> (vld == '0));
    p_occupancy_grows_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clear) |=> ($countones(vld) >= $past($countones(vld))));
    p_written_visible_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clear) |=> ($stable(lk_addr) -> hit));
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
    import ra_pkg::*;
#(
    parameter int SB_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  head_miss_i,
    input  logic [RA_PC_W-1:0]    head_pc_i,
    input  logic [RA_REG_W-1:0]   head_dst_i,
    input  logic                  miss_return_i,
    input  logic                  ret_valid_i,
    input  logic                  ret_is_load_i,
    input  logic                  ret_is_store_i,
    input  logic                  ret_dst_we_i,
    input  logic [RA_REG_W-1:0]   ret_dst_i,
    input  logic [RA_REG_W-1:0]   ret_src1_i,
    input  logic [RA_REG_W-1:0]   ret_src2_i,
    input  logic [RA_ADDR_W-1:0]  ret_addr_i,
    input  logic [RA_DATA_W-1:0]  ret_data_i,
    output logic                  ckpt_save_o,
    output logic                  ckpt_restore_o,
    output logic                  flush_o,
    output logic                  commit_suppress_o,
    output logic [RA_PC_W-1:0]    restart_pc_o,
    output logic                  ret_poison_o,
    output logic                  pf_valid_o,
    output logic [RA_ADDR_W-1:0]  pf_addr_o,
    output logic                  fwd_hit_o,
    output logic [RA_DATA_W-1:0]  fwd_data_o
);
    ra_state_e            state;
    ra_ctl_t              ctl;
    ra_retire_t           r;
    logic [RA_REG_W-1:0]  bogus_dst;
    logic                 set_bogus, clear_all;
    logic                 inv1, inv2;
    logic                 sb_hit, sb_dinv;
    logic [RA_DATA_W-1:0] sb_data;
    logic                 act, is_ld, is_st, ld_hit, poison;
    logic                 trk_we, sb_we;

    always_comb begin
        r.valid  = ret_valid_i;
        r.kind   = ra_decode(ret_is_load_i, ret_is_store_i);
        r.dst_we = ret_dst_we_i;
        r.dst    = ret_dst_i;
        r.src1   = ret_src1_i;
        r.src2   = ret_src2_i;
        r.addr   = ret_addr_i;
        r.data   = ret_data_i;
    end

    ra_mode_fsm u_fsm (
        .clk(clk), .rst(rst),
        .head_miss(head_miss_i), .head_pc(head_pc_i), .head_dst(head_dst_i),
        .miss_return(miss_return_i),
        .state(state), .ctl(ctl), .restart_pc(restart_pc_o),
        .bogus_dst(bogus_dst), .set_bogus(set_bogus), .clear_all(clear_all)
    );

    ra_poison_tracker u_trk (
        .clk(clk), .rst(rst), .clear_all(clear_all),
        .set_bogus(set_bogus), .bogus_dst(bogus_dst),
        .rd1(r.src1), .rd2(r.src2), .inv1(inv1), .inv2(inv2),
        .wr_en(trk_we), .wr_dst(r.dst), .wr_val(poison)
    );

    ra_spec_store_buf #(.DEPTH(SB_DEPTH)) u_sb (
        .clk(clk), .rst(rst), .clear(clear_all),
        .lk_addr(r.addr), .wr_en(sb_we), .wr_data(r.data), .wr_dinv(inv2),
        .hit(sb_hit), .rd_data(sb_data), .rd_dinv(sb_dinv)
    );

    always_comb begin
        act    = (state == RA_RUN) && r.valid;
        is_ld  = (r.kind == K_LOAD);
        is_st  = (r.kind == K_STORE);
        ld_hit = act && is_ld && !inv1 && sb_hit;
        unique case (r.kind)
            K_LOAD:  poison = inv1 || (sb_hit && sb_dinv);
            K_STORE: poison = 1'b0;
            default: poison = inv1 || inv2;
        endcase
        poison = poison && act;
        trk_we = act && r.dst_we && !is_st;
        sb_we  = act && is_st && !inv1;
    end

    assign ckpt_save_o       = ctl.save;
    assign ckpt_restore_o    = ctl.restore;
    assign flush_o           = ctl.flush;
    assign commit_suppress_o = ctl.suppress;
    assign ret_poison_o      = poison;
    assign pf_valid_o        = act && is_ld && !inv1 && !sb_hit;
    assign pf_addr_o         = pf_valid_o ? r.addr : '0;
    assign fwd_hit_o         = ld_hit;
    assign fwd_data_o        = ld_hit ? sb_data : '0;

    p_pf_only_runahead_r12: assert property (@(posedge clk) disable iff (rst)
        (pf_valid_o || fwd_hit_o || ret_poison_o) |-> commit_suppress_o);
    p_fwd_or_pf_r9: assert property (@(posedge clk) disable iff (rst)
        !(fwd_hit_o && pf_valid_o));
    p_restore_with_flush_r4: assert property (@(posedge clk) disable iff (rst)
        ckpt_restore_o |-> (flush_o && !commit_suppress_o));
endmodule

// File: tb/test_runahead_ctrl.sv
module test_runahead_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        head_miss = 0, miss_ret = 0;
    logic [31:0] head_pc = 0;
    logic [4:0]  head_dst = 0;
    logic        rv = 0, rld = 0, rst_st = 0, rwe = 0;
    logic [4:0]  rdst = 0, rs1 = 0, rs2 = 0;
    logic [31:0] raddr = 0, rdata = 0;

    logic        o_save, o_rest, o_flush, o_sup, o_poison, o_pf, o_fwd;
    logic [31:0] o_rpc, o_pfa, o_fwdd;

    always #2.5 clk = ~clk;

    runahead_ctrl i_runahead_ctrl (
        .clk(clk), .rst(rst),
        .head_miss_i(head_miss), .head_pc_i(head_pc), .head_dst_i(head_dst),
        .miss_return_i(miss_ret),
        .ret_valid_i(rv), .ret_is_load_i(rld), .ret_is_store_i(rst_st),
        .ret_dst_we_i(rwe), .ret_dst_i(rdst), .ret_src1_i(rs1), .ret_src2_i(rs2),
        .ret_addr_i(raddr), .ret_data_i(rdata),
        .ckpt_save_o(o_save), .ckpt_restore_o(o_rest), .flush_o(o_flush),
        .commit_suppress_o(o_sup), .restart_pc_o(o_rpc),
        .ret_poison_o(o_poison), .pf_valid_o(o_pf), .pf_addr_o(o_pfa),
        .fwd_hit_o(o_fwd), .fwd_data_o(o_fwdd)
    );

    // behavioural reference model
    localparam int DEPTH = 4;
    int          m_st;          // 0 normal, 1 save, 2 runahead, 3 restore
    bit          m_inv [32];
    logic [31:0] m_pc;
    logic [4:0]  m_dst;
    logic [31:0] q_a[$], q_d[$];
    bit          q_i[$];

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    bit          e_poison, e_pf, e_fwd;
    logic [31:0] e_pfa, e_fwdd;
    int          e_idx;

    function automatic int find(logic [31:0] a);
        for (int i = 0; i < q_a.size(); i++) if (q_a[i] == a) return i;
        return -1;
    endfunction

    task automatic expect_ret();
        bit a1, a2;
        e_poison = 0; e_pf = 0; e_fwd = 0; e_pfa = 0; e_fwdd = 0; e_idx = -1;
        if (m_st == 2 && rv) begin
            a1 = m_inv[rs1];
            a2 = m_inv[rs2];
            if (rst_st) begin
                e_poison = 0;
            end else if (rld) begin
                e_idx = find(raddr);
                if (a1) e_poison = 1;
                else if (e_idx >= 0) begin
                    e_fwd = 1; e_fwdd = q_d[e_idx]; e_poison = q_i[e_idx];
                end else begin
                    e_pf = 1; e_pfa = raddr;
                end
            end else begin
                e_poison = a1 | a2;
            end
        end
    endtask

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        expect_ret();
        check("ckpt_save R2", 32'(o_save), 32'(m_st == 1));
        check("suppress R3", 32'(o_sup), 32'(m_st == 2));
        check("restore R4", 32'(o_rest), 32'(m_st == 3));
        check("flush R4", 32'(o_flush), 32'(m_st == 3));
        check("restart_pc R4", o_rpc, (m_st == 3) ? m_pc : 32'h0);
        check("poison R7", 32'(o_poison), 32'(e_poison));
        check("pf_valid R8", 32'(o_pf), 32'(e_pf));
        check("pf_addr R8", o_pfa, e_pfa);
        check("fwd_hit R9", 32'(o_fwd), 32'(e_fwd));
        check("fwd_data R9", o_fwdd, e_fwdd);
    endtask

    task automatic model_step();
        if (rst) begin
            m_st = 0; m_pc = 0; m_dst = 0;
            for (int i = 0; i < 32; i++) m_inv[i] = 0;
            q_a.delete(); q_d.delete(); q_i.delete();
            return;
        end
        case (m_st)
            0: if (head_miss) begin m_st = 1; m_pc = head_pc; m_dst = head_dst; end
            1: begin
                if (m_dst != 0) m_inv[m_dst] = 1;
                m_st = miss_ret ? 3 : 2;
            end
            2: begin
                expect_ret();
                if (rv) begin
                    if (rst_st) begin
                        if (!m_inv[rs1]) begin
                            e_idx = find(raddr);
                            if (e_idx >= 0) begin
                                q_d[e_idx] = rdata; q_i[e_idx] = m_inv[rs2];
                            end else begin
                                if (q_a.size() == DEPTH) begin
                                    void'(q_a.pop_front()); void'(q_d.pop_front()); void'(q_i.pop_front());
                                end
                                q_a.push_back(raddr); q_d.push_back(rdata); q_i.push_back(m_inv[rs2]);
                            end
                        end
                    end else if (rwe && rdst != 0) begin
                        m_inv[rdst] = e_poison;
                    end
                end
                if (miss_ret) m_st = 3;
            end
            default: begin
                for (int i = 0; i < 32; i++) m_inv[i] = 0;
                q_a.delete(); q_d.delete(); q_i.delete();
                m_st = 0;
            end
        endcase
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
        @(posedge clk);
        model_step();
        #1;
    endtask

    task automatic idle();
        head_miss = 0; miss_ret = 0; rv = 0; rld = 0; rst_st = 0; rwe = 0;
        rdst = 0; rs1 = 0; rs2 = 0; raddr = 0; rdata = 0;
    endtask

    task automatic op(bit ld, bit st, bit we, logic [4:0] d, logic [4:0] s1,
                      logic [4:0] s2, logic [31:0] a, logic [31:0] dt);
        idle();
        rv = 1; rld = ld; rst_st = st; rwe = we; rdst = d; rs1 = s1; rs2 = s2;
        raddr = a; rdata = dt;
        cyc();
        idle();
    endtask

    task automatic enter(logic [31:0] pc, logic [4:0] d);
        idle(); head_miss = 1; head_pc = pc; head_dst = d;
        cyc();              // normal -> save
        idle(); cyc();      // save cycle
    endtask

    task automatic leave();
        idle(); miss_ret = 1; cyc();
        idle(); cyc();      // restore cycle
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) cyc();
        rst = 0;
        cur_req = "R1"; cyc(); cyc();

        cur_req = "R12";   // retirement in normal mode has no effect
        op(0, 1, 0, 0, 1, 2, 32'h40, 32'h11);
        op(1, 0, 1, 3, 1, 0, 32'h40, 0);
        idle(); miss_ret = 1; cyc(); idle();

        cur_req = "R2"; enter(32'h1000, 5'd5);
        cur_req = "R3"; idle(); cyc();
        cur_req = "R12"; idle(); head_miss = 1; cyc(); idle();
        cur_req = "R6"; op(0, 0, 1, 6, 5, 0, 0, 0);
        cur_req = "R7";
        op(0, 0, 1, 7, 0, 6, 0, 0);
        op(0, 0, 1, 6, 1, 2, 0, 0);
        op(0, 0, 1, 8, 6, 0, 0, 0);
        op(0, 0, 1, 0, 5, 0, 0, 0);
        op(0, 0, 1, 9, 0, 0, 0, 0);
        op(0, 0, 0, 1, 7, 0, 0, 0);
        op(0, 0, 0, 9, 1, 0, 0, 0);
        cur_req = "R8";
        op(1, 0, 1, 10, 1, 0, 32'h200, 0);
        op(1, 0, 1, 11, 7, 0, 32'h204, 0);
        op(0, 0, 1, 12, 11, 0, 0, 0);
        cur_req = "R9";
        op(0, 1, 0, 0, 1, 2, 32'h40, 32'hAAAA);
        op(1, 0, 1, 13, 1, 0, 32'h40, 0);
        op(0, 1, 0, 0, 1, 5, 32'h44, 32'hBBBB);
        op(1, 0, 1, 14, 1, 0, 32'h44, 0);
        op(0, 1, 1, 15, 7, 2, 32'h48, 32'hCCCC);
        op(1, 0, 1, 15, 0, 0, 32'h48, 0);
        op(1, 1, 1, 16, 0, 0, 32'h4C, 32'hDDDD);
        op(1, 0, 0, 0, 0, 0, 32'h4C, 0);
        cur_req = "R10";
        op(0, 1, 0, 0, 0, 0, 32'h50, 32'h5050);
        op(0, 1, 0, 0, 0, 0, 32'h44, 32'h4444);
        op(0, 1, 0, 0, 0, 0, 32'h54, 32'h5454);
        op(1, 0, 0, 0, 0, 0, 32'h40, 0);
        op(1, 0, 0, 0, 0, 0, 32'h44, 0);
        op(1, 0, 0, 0, 0, 0, 32'h4C, 0);
        op(1, 0, 0, 0, 0, 0, 32'h54, 0);
        cur_req = "R4"; leave(); cyc();
        cur_req = "R11"; enter(32'h2000, 5'd0); cyc();
        op(0, 0, 1, 20, 7, 5, 0, 0);
        op(1, 0, 0, 0, 0, 0, 32'h54, 0);
        cur_req = "R4"; leave();
        cur_req = "R5";
        idle(); head_miss = 1; head_pc = 32'h3000; head_dst = 5'd4; cyc();
        idle(); miss_ret = 1; cyc();
        idle(); cyc(); cyc();
        cur_req = "R11"; enter(32'h3100, 5'd0);
        op(0, 0, 1, 21, 4, 0, 0, 0);
        leave();

        cur_req = "RAND";
        for (int n = 0; n < 6000; n++) begin
            idle();
            head_miss = ($urandom_range(0, 5) == 0);
            head_pc   = $urandom;
            head_dst  = 5'($urandom_range(0, 7));
            miss_ret  = ($urandom_range(0, 11) == 0);
            rv        = $urandom_range(0, 1);
            rld       = $urandom_range(0, 1);
            rst_st    = ($urandom_range(0, 3) == 0);
            rwe       = $urandom_range(0, 1);
            rdst      = 5'($urandom_range(0, 7));
            rs1       = 5'($urandom_range(0, 7));
            rs2       = 5'($urandom_range(0, 7));
            raddr     = 32'h100 + 32'($urandom_range(0, 5)) * 4;
            rdata     = $urandom;
            cyc();
        end
        idle(); cyc();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule